// File: doc/BRIEF.md
# Rotating Row-Bank Buffer with Kernel-Row Crossbar

This block holds up to seven image rows of packed 16-bit pixel words close to a convolution engine. Each kernel row gets its own bank. A crossbar presents every bank to a fixed processing-row output, so that output 0 always shows the top row of the current convolution window. The same column index addresses all seven outputs at once, and each output carries a flag that says whether the row it shows is complete.

After a configuration pulse sets the kernel height (1 to 7), the first rows stream into banks 0, 1, 2 and so on, a whole row at a time. When the window steps down one image row, no data moves between banks. The bank that holds the oldest row is cleared and refilled with the next image row, and a head pointer advances so that the crossbar rotation keeps the outputs in top-to-bottom order. While the refill runs, the other rows stay readable.

Top module: `rowbank_xbar`

## Requirements
- R1: After reset the kernel height is 7, the head pointer and fill position are zero, and every `out_valid` bit is 0.
- R2: A `cfg_apply` pulse loads the height from `cfg_height`, with 0 taken as 1 and values above the bank count taken as the bank count. It also empties all banks, sets the head to bank 0 and starts filling at bank 0, column 0. Every `out_valid` bit is 0 in the cycle after the pulse.
- R3: While filling, each `wr_valid` cycle stores `wr_data` at the next column of the fill bank. Columns run from 0 to ROW_LEN-1. A bank becomes valid once its last column is written. During priming the fill then moves to the next bank, until banks 0 to height-1 are all full.
- R4: Output port k (bits 16k+15 down to 16k of `out_words`) shows column `rd_col` of bank (head+k) mod height. The path from `rd_col` to the output has no register, and `out_valid[k]` is that bank's full flag. As a result, port k carries image row base+k, where base counts the accepted advances.
- R5: Ports k with k at or above the height drive all-zero data with `out_valid[k]`=0.
- R6: A `row_adv` pulse given while no fill is running empties the head bank and makes it the fill target at column 0. The head then moves to (head+1) mod height, so from the next cycle `out_valid[height-1]` is 0 until the new row is complete.
- R7: A `row_adv` pulse given while a fill is running is ignored: the head, the fill position and all valid flags stay as they were.
- R8: A `wr_valid` cycle given while no fill is running is ignored, and no bank contents change.
- R9: During a refill, ports 0 to height-2 stay valid and show their rows unchanged.
- R10: With height 1, every accepted advance empties the single bank and refills it, and port 0 shows the newest row once it is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_apply | input | 1 | Load height and restart the buffer |
| cfg_height | input | 3 | Kernel height, 1 to 7 |
| wr_valid | input | 1 | Pixel word write strobe |
| wr_data | input | 16 | Packed pixel word to store |
| row_adv | input | 1 | Window steps down one image row |
| rd_col | input | 4 | Column index read on all ports |
| out_words | output | 112 | Seven pixel words, port k at bits 16k+15:16k |
| out_valid | output | 7 | Port k shows a complete row |

## Verification
The hardest state to reach is a refill in progress while the head sits partway around the ring. In that state the bank being written is not at port 0 and the rotation wraps past the last bank. The bench reaches it by priming, then issuing more advances than the height, each followed by a refill. At the end it stops one refill halfway and reads every port. It also sends an advance in the middle of a priming fill, and sends a full row of writes while no fill is running. Both must be ignored, which the bench confirms by reading the ports afterwards.

// File: rtl/rbx_pkg.sv
// Shared helpers for the rotating row-bank buffer.
// Assumes operands of wrap_add are each below the modulus.
package rbx_pkg;
    // Add two ring positions and wrap once at the modulus.
    function automatic int wrap_add(input int a, input int b, input int m);
        int s;
        s = a + b;
        if (s >= m) s = s - m;
        return s;
    endfunction
endpackage

// File: rtl/rb_bank.sv
// One row bank: ROW_LEN words of W bits, single write port and
// asynchronous read port. Assumes waddr/raddr are below ROW_LEN.
module rb_bank #(
    parameter int W       = 16,
    parameter int ROW_LEN = 16,
    localparam int COL_W  = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [COL_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [COL_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [ROW_LEN];

    // Store one word per write strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_LEN; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read path with no register.
    assign rdata = mem[raddr];
endmodule

// File: rtl/rb_ptr_ctrl.sv
// Pointer control: holds the height, head (oldest bank), fill bank and
// column, and per-bank full flags. Priming fills banks in order; later
// advances recycle the head bank. Assumes one-hot use of the commands
// is not required: cfg_apply wins over row_adv, which wins over writes.
module rb_ptr_ctrl #(
    parameter int NB      = 7,
    parameter int ROW_LEN = 16,
    localparam int BI_W   = $clog2(NB),
    localparam int HG_W   = $clog2(NB + 1),
    localparam int COL_W  = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_apply,
    input  logic [HG_W-1:0]  cfg_height,
    input  logic             row_adv,
    input  logic             wr_valid,
    output logic [HG_W-1:0]  height_q,
    output logic [BI_W-1:0]  head_q,
    output logic [BI_W-1:0]  fill_bank_q,
    output logic [COL_W-1:0] fill_col_q,
    output logic             filling_q,
    output logic [NB-1:0]    full_q,
    output logic [NB-1:0]    bank_we
);
    logic            primed_q;
    logic [HG_W-1:0] h_new;
    logic            adv_ok, wr_ok, last_col, last_bank, head_wrap;

    // Clamp the requested height into 1..NB.
    always_comb begin
        if (cfg_height == '0)              h_new = HG_W'(1);
        else if (cfg_height > HG_W'(NB))   h_new = HG_W'(NB);
        else                               h_new = cfg_height;
    end

    // Decode command acceptance and fill boundaries.
    always_comb begin
        adv_ok    = row_adv && !filling_q;
        wr_ok     = wr_valid && filling_q;
        last_col  = (fill_col_q == COL_W'(ROW_LEN - 1));
        last_bank = (fill_bank_q == BI_W'(height_q - HG_W'(1)));
        head_wrap = (head_q == BI_W'(height_q - HG_W'(1)));
    end

    // Steer the write strobe to the fill bank.
    always_comb begin
        for (int i = 0; i < NB; i++) bank_we[i] = wr_ok && (fill_bank_q == BI_W'(i));
    end

    // Advance pointers, fill position and full flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            height_q    <= HG_W'(NB);
            head_q      <= '0;
            fill_bank_q <= '0;
            fill_col_q  <= '0;
            filling_q   <= 1'b1;
            primed_q    <= 1'b0;
            full_q      <= '0;
        end else if (cfg_apply) begin
            height_q    <= h_new;
            head_q      <= '0;
            fill_bank_q <= '0;
            fill_col_q  <= '0;
            filling_q   <= 1'b1;
            primed_q    <= 1'b0;
            full_q      <= '0;
        end else if (adv_ok) begin
            full_q[head_q] <= 1'b0;
            fill_bank_q    <= head_q;
            fill_col_q     <= '0;
            filling_q      <= 1'b1;
            head_q         <= head_wrap ? '0 : head_q + BI_W'(1);
        end else if (wr_ok) begin
            fill_col_q <= last_col ? '0 : fill_col_q + COL_W'(1);
            if (last_col) begin
                full_q[fill_bank_q] <= 1'b1;
                if (!primed_q && !last_bank) begin
                    fill_bank_q <= fill_bank_q + BI_W'(1);
                end else begin
                    filling_q <= 1'b0;
                    primed_q  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rb_xbar.sv
// Crossbar: port k selects bank (head+k) mod height; ports at or above
// the height drive zero and invalid. Assumes head < height <= NB.
module rb_xbar #(
    parameter int NB     = 7,
    parameter int W      = 16,
    localparam int BI_W  = $clog2(NB),
    localparam int HG_W  = $clog2(NB + 1)
) (
    input  logic [BI_W-1:0]       head,
    input  logic [HG_W-1:0]       height,
    input  logic [NB-1:0][W-1:0]  bank_rd,
    input  logic [NB-1:0]         bank_full,
    output logic [NB-1:0][W-1:0]  port_data,
    output logic [NB-1:0]         port_valid
);
    import rbx_pkg::*;

    // Rotate bank selection per port and mask unused ports.
    always_comb begin
        for (int k = 0; k < NB; k++) begin
            logic [BI_W-1:0] sel;
            sel = BI_W'(wrap_add(int'(head), k, int'(height)));
            if (k < int'(height)) begin
                port_data[k]  = bank_rd[sel];
                port_valid[k] = bank_full[sel];
            end else begin
                port_data[k]  = '0;
                port_valid[k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rowbank_xbar.sv
// Top: NB row banks, pointer control and rotating crossbar. One column
// index reads all ports in the same cycle. Assumes rows are written
// whole, ROW_LEN words in column order.
module rowbank_xbar #(
    parameter int NUM_BANKS = 7,
    parameter int WORD_W    = 16,
    parameter int ROW_LEN   = 16,
    localparam int BI_W     = $clog2(NUM_BANKS),
    localparam int HG_W     = $clog2(NUM_BANKS + 1),
    localparam int COL_W    = $clog2(ROW_LEN)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_apply,
    input  logic [HG_W-1:0]             cfg_height,
    input  logic                        wr_valid,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        row_adv,
    input  logic [COL_W-1:0]            rd_col,
    output logic [NUM_BANKS*WORD_W-1:0] out_words,
    output logic [NUM_BANKS-1:0]        out_valid
);
    logic [HG_W-1:0]                   height_q;
    logic [BI_W-1:0]                   head_q, fill_bank_q;
    logic [COL_W-1:0]                  fill_col_q;
    logic                              filling_q;
    logic [NUM_BANKS-1:0]              full_q, bank_we;
    logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rd, port_data;

    rb_ptr_ctrl #(.NB(NUM_BANKS), .ROW_LEN(ROW_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_height(cfg_height),
        .row_adv(row_adv), .wr_valid(wr_valid), .height_q(height_q), .head_q(head_q),
        .fill_bank_q(fill_bank_q), .fill_col_q(fill_col_q), .filling_q(filling_q),
        .full_q(full_q), .bank_we(bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rb_bank #(.W(WORD_W), .ROW_LEN(ROW_LEN)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .waddr(fill_col_q),
            .wdata(wr_data), .raddr(rd_col), .rdata(bank_rd[b])
        );
    end

    rb_xbar #(.NB(NUM_BANKS), .W(WORD_W)) u_xbar (
        .head(head_q), .height(height_q), .bank_rd(bank_rd), .bank_full(full_q),
        .port_data(port_data), .port_valid(out_valid)
    );

    // Flatten the port words onto the output bus.
    assign out_words = port_data;
endmodule

// File: rtl/rb_checker.sv
// Checker for rowbank_xbar: pointer range, unused-port masking, apply
// clearing, and advance rotation/ignore rules. Bound to the top below.
module rb_checker #(
    parameter int NB   = 7,
    parameter int W    = 16,
    parameter int BI_W = 3,
    parameter int HG_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_apply,
    input logic            row_adv,
    input logic [HG_W-1:0] height,
    input logic [BI_W-1:0] head,
    input logic            filling,
    input logic [NB-1:0]   out_valid,
    input logic [NB*W-1:0] out_words
);
    AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(head) < int'(height)); // R4

    AST_APPLY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_apply |=> (out_valid == '0)); // R2

    AST_ADV_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (row_adv && !filling && !cfg_apply) |=>
        (int'(head) == ((int'($past(head)) + 1 == int'($past(height))) ? 0 : int'($past(head)) + 1))); // R6

    AST_ADV_BOTTOM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (row_adv && !filling && !cfg_apply) |=> !out_valid[int'(height) - 1]); // R6

    AST_BUSY_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (row_adv && filling && !cfg_apply) |=> $stable(head)); // R7

    for (genvar k = 0; k < NB; k++) begin : g_port
        AST_UNUSED_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (k >= int'(height)) |-> (!out_valid[k] && out_words[k*W +: W] == '0)); // R5
    end
endmodule

bind rowbank_xbar rb_checker #(.NB(NUM_BANKS), .W(WORD_W), .BI_W(BI_W), .HG_W(HG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .row_adv(row_adv),
    .height(height_q), .head(head_q), .filling(filling_q),
    .out_valid(out_valid), .out_words(out_words)
);

// File: tb/sim_rowbank_xbar.sv
module sim_rowbank_xbar;
    localparam int NB = 7, W = 16, RL = 16;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              cfg_apply = 1'b0, wr_valid = 1'b0, row_adv = 1'b0;
    logic [2:0]        cfg_height = '0;
    logic [W-1:0]      wr_data = '0;
    logic [3:0]        rd_col = '0;
    logic [NB*W-1:0]   out_words;
    logic [NB-1:0]     out_valid;

    int n_cmp = 0, n_bad = 0;
    int mh = 7, rows_wr = 0, base = 0;

    // Each entry: height, number of advance-and-refill steps.
    localparam int VEC [6][2] = '{'{7, 9}, '{3, 4}, '{1, 3}, '{5, 6}, '{2, 2}, '{4, 8}};

    always #2.5 clk = ~clk;

    rowbank_xbar u0 (
        .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_height(cfg_height),
        .wr_valid(wr_valid), .wr_data(wr_data), .row_adv(row_adv), .rd_col(rd_col),
        .out_words(out_words), .out_valid(out_valid)
    );

    function automatic logic [W-1:0] pat(input int r, input int c);
        return W'(r * 97 + c * 13 + 16'h1234);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_apply(input int h);
        cfg_apply = 1'b1; cfg_height = 3'(h);
        @(negedge clk);
        cfg_apply = 1'b0;
        mh = (h == 0) ? 1 : h;
        rows_wr = 0; base = 0;
    endtask

    task automatic write_words(input int r, input int c0, input int c1);
        for (int c = c0; c < c1; c++) begin
            wr_valid = 1'b1; wr_data = pat(r, c);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic write_row(input int r);
        write_words(r, 0, RL);
        rows_wr++;
    endtask

    task automatic advance();
        row_adv = 1'b1;
        @(negedge clk);
        row_adv = 1'b0;
        base++;
    endtask

    // Read every column and compare every port against the row model.
    task automatic check_ports(input string req);
        for (int c = 0; c < RL; c++) begin
            rd_col = 4'(c);
            #1;
            for (int k = 0; k < NB; k++) begin
                logic ev;
                ev = (k < mh) && (base + k < rows_wr);
                chk(req, $sformatf("valid port %0d col %0d", k, c), 32'(out_valid[k]), 32'(ev));
                if (k >= mh)
                    chk(req, $sformatf("zero port %0d", k), 32'(out_words[k*W +: W]), 32'h0);
                else if (ev)
                    chk(req, $sformatf("data port %0d col %0d", k, c), 32'(out_words[k*W +: W]), 32'(pat(base + k, c)));
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset nothing is valid, height 7 so every port maps a bank.
        chk("R1", "out_valid after reset", 32'(out_valid), 32'h0);
        chk("R1", "out_words after reset", 32'(|out_words), 32'h0);
        mh = 7; rows_wr = 0; base = 0;
        write_row(0);
        check_ports("R1");

        // Table walk: prime, then advance and refill past the ring wrap.
        for (int v = 0; v < 6; v++) begin
            do_apply(VEC[v][0]);
            chk("R2", "valid after apply", 32'(out_valid), 32'h0);
            for (int r = 0; r < mh; r++) write_row(r);
            check_ports("R3");
            for (int a = 0; a < VEC[v][1]; a++) begin
                advance();
                check_ports("R6");
                write_row(rows_wr);
                check_ports("R4");
            end
        end

        // R2: height 0 is taken as 1; R5: other ports stay quiet.
        do_apply(0);
        write_row(0);
        check_ports("R5");

        // R7: advance during a priming fill is ignored.
        do_apply(3);
        write_row(0);
        write_words(1, 0, RL / 2);
        row_adv = 1'b1; @(negedge clk); row_adv = 1'b0;
        write_words(1, RL / 2, RL); rows_wr++;
        write_row(2);
        check_ports("R7");

        // R8: writes with no fill running leave all banks unchanged.
        for (int c = 0; c < RL; c++) begin
            wr_valid = 1'b1; wr_data = 16'hDEAD ^ 16'(c);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        check_ports("R8");

        // R9: halfway through a refill the upper rows remain readable.
        advance();
        write_words(rows_wr, 0, RL / 2);
        check_ports("R9");
        write_words(rows_wr, RL / 2, RL); rows_wr++;
        check_ports("R9");

        // R10: single-bank height refills the same bank every step.
        do_apply(1);
        write_row(0);
        for (int a = 0; a < 3; a++) begin
            advance();
            check_ports("R10");
            write_row(rows_wr);
            check_ports("R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule